// File: doc/BRIEF.md
# Byte-Fed Signed Multiply-Accumulate Filter Engine

This block computes the sum of products at the core of an FIR filter. The host first places signed 16-bit samples and signed 16-bit coefficients in a shared byte-wide synchronous SRAM. It then presents a sample base address, a coefficient base address and a tap count, and pulses `start`. The engine fetches each operand as two bytes and multiplies sample by coefficient into a 32-bit product. It adds every product into a 32-bit accumulator that wraps on overflow. When the last product has been added it raises `done`, and the accumulator and a sticky overflow flag can then be read at the ports.

A tap takes four memory cycles, one per byte. The multiply and the accumulate of tap i run in a pipeline behind the byte fetches of tap i+1, so a run of N taps sustains one tap every four clocks. The SRAM returns read data one clock after the address. Operand width, accumulator width, address width, tap-count width and the choice between a registered and a combinational multiplier are parameters.

Top module: `mac_fir_engine`

## Requirements
- R1: A `start` pulse seen while idle clears the accumulator, the overflow flag and `done`, and captures both base addresses and the tap count. Changing those inputs after the accepting edge has no effect on the run.
- R2: Tap t issues reads in this order: sample low byte at `smp_base+2t`, sample high byte at `smp_base+2t+1`, coefficient low byte at `coef_base+2t`, coefficient high byte at `coef_base+2t+1`. It issues exactly one read per cycle, and `mem_rd` is high only while reads are being issued. Read data is taken one cycle after its address.
- R3: The final `acc` is the two's-complement sum, modulo 2^32, of the signed 16 x 16 products of the tap operand pairs.
- R4: With the registered multiplier (default), `done` is first high after the 4N+3-th rising edge that follows the accepting edge, for N taps. This is one tap per four cycles.
- R5: `overflow` is set when any signed accumulation overflows. It stays set until the next accepted `start`.
- R6: A `start` pulse that arrives while the engine is busy, during fetch or during the pipeline drain, is ignored. The result and the completion cycle are unchanged.
- R7: A tap count of zero raises `done` at the accepting edge itself, with `acc` equal to zero.
- R8: After completion, `done`, `acc` and `overflow` hold until the next accepted `start`. A `start` in the cycle right after `done` rises is accepted.
- R9: Operand addresses wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; ignored while busy |
| smp_base | input | ADDR_W | Byte address of the first sample |
| coef_base | input | ADDR_W | Byte address of the first coefficient |
| tap_count | input | CNT_W | Number of taps in the run |
| mem_addr | output | ADDR_W | SRAM byte address |
| mem_rd | output | 1 | SRAM read strobe |
| mem_rdata | input | 8 | SRAM read data, valid one cycle after the address |
| done | output | 1 | Run complete; result valid |
| acc | output | ACC_W | Accumulated sum of products |
| overflow | output | 1 | Sticky signed-overflow flag |

## Verification
Three things can happen in the same cycle. The accumulator adds the product of one tap, the multiplier forms the product of the next, and the byte fetch of the tap after that moves on. At the end of a run, the last accumulation and the setting of `done` fall on one edge. The bench checks that the value seen with `done` already includes the final product, and that a `start` on the cycle after `done` is accepted. In a separate run a `start` arrives during the busy window, and the bench checks that the result and the completion cycle are still exactly those of a run without it.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
   localparam int BYTE_W = 8;

   function automatic int phase_bits(input int opnd_bytes);
      return (2 * opnd_bytes > 1) ? $clog2(2 * opnd_bytes) : 1;
   endfunction
endpackage

// File: rtl/mfe_fetch.sv
module mfe_fetch
   import mfe_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int CNT_W      = 8,
   parameter int OPND_BYTES = 2,
   parameter int PH_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] smp_base,
   input  logic [ADDR_W-1:0] coef_base,
   input  logic [CNT_W-1:0]  tap_count,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic [PH_W-1:0]   phase
);
   localparam logic [PH_W-1:0]   LAST = PH_W'(2 * OPND_BYTES - 1);
   localparam logic [PH_W-1:0]   HALF = PH_W'(OPND_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(OPND_BYTES);

   logic              fetching;
   logic [PH_W-1:0]   ph;
   logic [CNT_W-1:0]  left;
   logic [ADDR_W-1:0] sptr, cptr;
   logic [PH_W-1:0]   ofs;
   logic              in_smp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetching <= 1'b0;
         ph       <= '0;
         left     <= '0;
         sptr     <= '0;
         cptr     <= '0;
      end else if (accept) begin
         fetching <= (tap_count != '0);
         ph       <= '0;
         left     <= tap_count;
         sptr     <= smp_base;
         cptr     <= coef_base;
      end else if (fetching) begin
         if (ph == LAST) begin
            ph   <= '0;
            sptr <= sptr + STEP;
            cptr <= cptr + STEP;
            left <= left - CNT_W'(1);
            if (left == CNT_W'(1)) fetching <= 1'b0;
         end else begin
            ph <= ph + PH_W'(1);
         end
      end
   end

   always_comb begin
      in_smp   = (ph < HALF);
      ofs      = in_smp ? ph : (ph - HALF);
      mem_addr = (in_smp ? sptr : cptr) + ADDR_W'(ofs);
   end

   assign mem_rd = fetching;
   assign phase  = ph;
endmodule

// File: rtl/mfe_assemble.sv
module mfe_assemble
   import mfe_pkg::*;
#(
   parameter int OPND_W = 16,
   parameter int PH_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mem_rd,
   input  logic [PH_W-1:0]          phase,
   input  logic [BYTE_W-1:0]        mem_rdata,
   output logic                     opv,
   output logic signed [OPND_W-1:0] smp,
   output logic signed [OPND_W-1:0] coef
);
   localparam int SH_W = 2 * OPND_W;
   localparam logic [PH_W-1:0] LAST = PH_W'(2 * (OPND_W / BYTE_W) - 1);

   logic            v_q;
   logic [PH_W-1:0] ph_q;
   logic [SH_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q  <= 1'b0;
         ph_q <= '0;
         sh   <= '0;
         opv  <= 1'b0;
      end else begin
         v_q  <= mem_rd;
         ph_q <= phase;
         opv  <= v_q && (ph_q == LAST);
         if (v_q) sh <= {mem_rdata, sh[SH_W-1:BYTE_W]};
      end
   end

   assign smp  = sh[OPND_W-1:0];
   assign coef = sh[SH_W-1:OPND_W];
endmodule

// File: rtl/mfe_mul.sv
module mfe_mul #(
   parameter int OPND_W  = 16,
   parameter int MUL_REG = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       opv,
   input  logic signed [OPND_W-1:0]   smp,
   input  logic signed [OPND_W-1:0]   coef,
   output logic                       pv,
   output logic signed [2*OPND_W-1:0] prod
);
   localparam int PROD_W = 2 * OPND_W;

   generate
      if (MUL_REG != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pv   <= 1'b0;
               prod <= '0;
            end else begin
               pv   <= opv;
               prod <= PROD_W'(smp) * PROD_W'(coef);
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign pv   = opv;
         assign prod = PROD_W'(smp) * PROD_W'(coef);
      end
   endgenerate
endmodule

// File: rtl/mfe_acc.sv
module mfe_acc #(
   parameter int ACC_W  = 32,
   parameter int PROD_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     accept,
   input  logic [CNT_W-1:0]         tap_count,
   input  logic                     pv,
   input  logic signed [PROD_W-1:0] prod,
   output logic [ACC_W-1:0]         acc,
   output logic                     overflow,
   output logic                     done,
   output logic                     busy
);
   logic [CNT_W-1:0]        left;
   logic signed [ACC_W-1:0] ext;
   logic [ACC_W-1:0]        sum;
   logic                    ovf_now;

   always_comb begin
      ext     = ACC_W'(prod);
      sum     = acc + ext;
      ovf_now = (acc[ACC_W-1] == ext[ACC_W-1]) && (sum[ACC_W-1] != acc[ACC_W-1]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         overflow <= 1'b0;
         done     <= 1'b0;
         busy     <= 1'b0;
         left     <= '0;
      end else if (accept) begin
         acc      <= '0;
         overflow <= 1'b0;
         done     <= (tap_count == '0);
         busy     <= (tap_count != '0);
         left     <= tap_count;
      end else if (busy && pv) begin
         acc      <= sum;
         overflow <= overflow | ovf_now;
         left     <= left - CNT_W'(1);
         if (left == CNT_W'(1)) begin
            done <= 1'b1;
            busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mac_fir_engine.sv
module mac_fir_engine
   import mfe_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int CNT_W   = 8,
   parameter int OPND_W  = 16,
   parameter int ACC_W   = 32,
   parameter int MUL_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] smp_base,
   input  logic [ADDR_W-1:0] coef_base,
   input  logic [CNT_W-1:0]  tap_count,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              done,
   output logic [ACC_W-1:0]  acc,
   output logic              overflow
);
   localparam int OPND_BYTES = OPND_W / BYTE_W;
   localparam int PH_W       = phase_bits(OPND_BYTES);
   localparam int PROD_W     = 2 * OPND_W;

   generate
      if (OPND_W % BYTE_W != 0 || OPND_W < BYTE_W) begin : g_bad_opnd
         $error("OPND_W must be a positive multiple of 8");
      end
      if (ACC_W < PROD_W) begin : g_bad_acc
         $error("ACC_W must hold a full product");
      end
      if (MUL_REG != 0 && MUL_REG != 1) begin : g_bad_mul
         $error("MUL_REG must be 0 or 1");
      end
      if (ADDR_W < 2 || CNT_W < 1) begin : g_bad_addr
         $error("ADDR_W and CNT_W too small");
      end
   endgenerate

   logic                     busy;
   logic                     accept;
   logic [PH_W-1:0]          phase;
   logic                     opv, pv;
   logic signed [OPND_W-1:0] smp, coef;
   logic signed [PROD_W-1:0] prod;

   assign accept = start && !busy;

   mfe_fetch #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OPND_BYTES(OPND_BYTES), .PH_W(PH_W)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .smp_base(smp_base), .coef_base(coef_base), .tap_count(tap_count),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .phase(phase)
   );

   mfe_assemble #(
      .OPND_W(OPND_W), .PH_W(PH_W)
   ) u_asm (
      .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .phase(phase),
      .mem_rdata(mem_rdata), .opv(opv), .smp(smp), .coef(coef)
   );

   mfe_mul #(
      .OPND_W(OPND_W), .MUL_REG(MUL_REG)
   ) u_mul (
      .clk(clk), .rst_n(rst_n), .opv(opv), .smp(smp), .coef(coef),
      .pv(pv), .prod(prod)
   );

   mfe_acc #(
      .ACC_W(ACC_W), .PROD_W(PROD_W), .CNT_W(CNT_W)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .accept(accept), .tap_count(tap_count),
      .pv(pv), .prod(prod), .acc(acc), .overflow(overflow),
      .done(done), .busy(busy)
   );
endmodule

// File: rtl/mfe_checker.sv
module mfe_checker #(
   parameter int ACC_W = 32,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             mem_rd,
   input logic             done,
   input logic             overflow,
   input logic [ACC_W-1:0] acc,
   input logic [CNT_W-1:0] tap_count
);
   a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && tap_count != '0) |=> (busy && !done && !overflow && acc == '0));

   a_r2_rd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> busy);

   a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(overflow) |-> $past(start && !busy));

   a_r6_busy_start_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> (busy || done));

   a_r7_zero_taps: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && tap_count == '0) |=> (done && !busy && acc == '0));

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(acc) && $stable(done) && $stable(overflow)));
endmodule

bind mac_fir_engine mfe_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_rd(mem_rd),
   .done(done), .overflow(overflow), .acc(acc), .tap_count(tap_count)
);

// File: tb/mac_fir_engine_tb.sv
module mac_fir_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int MEM_N = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] smp_base = '0;
   logic [AW-1:0] coef_base = '0;
   logic [7:0]    tap_count = '0;
   logic [AW-1:0] mem_addr;
   logic          mem_rd;
   logic [7:0]    mem_rdata;
   logic          done;
   logic [31:0]   acc;
   logic          overflow;

   logic [7:0]    mem [0:MEM_N-1];
   logic [AW-1:0] rd_log [0:63];
   int            nlog = 0;
   int            n_checks = 0;
   int            n_errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mac_fir_engine u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .smp_base(smp_base),
      .coef_base(coef_base), .tap_count(tap_count), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_rdata(mem_rdata), .done(done), .acc(acc),
      .overflow(overflow)
   );

   always @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= mem[mem_addr];
         if (nlog < 64) rd_log[nlog] <= mem_addr;
         nlog <= nlog + 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic put16(input int addr, input logic [15:0] v);
      mem[addr % MEM_N]       = v[7:0];
      mem[(addr + 1) % MEM_N] = v[15:8];
   endtask

   task automatic ref_model(input int sb, input int cb, input int n,
                            output logic [31:0] r, output logic o);
      r = '0;
      o = 1'b0;
      for (int t = 0; t < n; t++) begin
         logic signed [15:0] s, c;
         logic signed [31:0] p;
         logic [31:0] nr;
         s = {mem[(sb + 2*t + 1) % MEM_N], mem[(sb + 2*t) % MEM_N]};
         c = {mem[(cb + 2*t + 1) % MEM_N], mem[(cb + 2*t) % MEM_N]};
         p = s * c;
         nr = r + p;
         if (r[31] == p[31] && nr[31] != r[31]) o = 1'b1;
         r = nr;
      end
   endtask

   // Runs one filter pass; kill_at > 0 pulses start again in that busy cycle.
   task automatic run_filter(input int sb, input int cb, input int n,
                             input int kill_at, input string req);
      logic [31:0] exp_acc;
      logic        exp_ovf;
      int          log0;
      int          cyc;
      ref_model(sb, cb, n, exp_acc, exp_ovf);
      smp_base  = AW'(sb);
      coef_base = AW'(cb);
      tap_count = 8'(n);
      start     = 1'b1;
      log0      = nlog;
      @(posedge clk);
      @(negedge clk);
      start     = 1'b0;
      smp_base  = ~AW'(sb);
      coef_base = ~AW'(cb);
      tap_count = 8'(n + 3);
      cyc = -1;
      if (n == 0) begin
         check(done === 1'b1, "R7", "done at accept edge", done, 1);
         cyc = 0;
      end else begin
         check(done === 1'b0 && acc === 32'h0 && overflow === 1'b0, req,
               "R1 cleared after start", {done, overflow, acc}, 0);
         for (int k = 1; k < 4 * n + 40; k++) begin
            @(posedge clk);
            @(negedge clk);
            start = (k == kill_at);
            if (done === 1'b1) begin
               cyc = k;
               break;
            end
         end
         start = 1'b0;
         check(cyc == 4 * n + 3, req, "R4 completion cycle", cyc, 4 * n + 3);
         check(nlog - log0 == 4 * n, req, "R2 read count", nlog - log0, 4 * n);
         for (int t = 0; t < n && log0 + 4*t + 3 < 64; t++) begin
            check(rd_log[log0 + 4*t]     == AW'(sb + 2*t)     &&
                  rd_log[log0 + 4*t + 1] == AW'(sb + 2*t + 1) &&
                  rd_log[log0 + 4*t + 2] == AW'(cb + 2*t)     &&
                  rd_log[log0 + 4*t + 3] == AW'(cb + 2*t + 1),
                  "R2", "byte order/R9 wrap", rd_log[log0 + 4*t], AW'(sb + 2*t));
         end
      end
      check(acc === exp_acc, req, "R3 result", acc, exp_acc);
      check(overflow === exp_ovf, req, "R5 overflow", overflow, exp_ovf);
   endtask

   task automatic t_reset;
      check(done === 1'b0 && acc === 32'h0 && overflow === 1'b0 && mem_rd === 1'b0,
            "R1", "reset state", {done, overflow, mem_rd, acc}, 0);
   endtask

   task automatic t_single;
      put16(10, 16'd300);
      put16(20, 16'hFFF9);
      run_filter(10, 20, 1, 0, "R3");
   endtask

   task automatic t_multi;
      for (int i = 0; i < 8; i++) begin
         put16(40 + 2*i, 16'(i * 4099 - 15000));
         put16(80 + 2*i, 16'(12000 - i * 3001));
      end
      run_filter(40, 80, 8, 0, "R3");
   endtask

   task automatic t_overflow;
      put16(100, 16'h8000); put16(102, 16'h8000);
      put16(200, 16'h8000); put16(202, 16'h8000);
      run_filter(100, 200, 2, 0, "R5");
      run_filter(10, 20, 1, 0, "R5");
   endtask

   task automatic t_ignore_busy;
      logic [31:0] a0;
      run_filter(40, 80, 4, 6, "R6");
      a0 = acc;
      run_filter(40, 80, 4, 4 * 4 + 1, "R6");
      check(acc === a0, "R6", "late start ignored", acc, a0);
   endtask

   task automatic t_zero;
      run_filter(40, 80, 0, 0, "R7");
   endtask

   task automatic t_hold_and_b2b;
      logic [31:0] a0;
      run_filter(40, 80, 3, 0, "R8");
      a0 = acc;
      repeat (3) @(negedge clk);
      check(done === 1'b1 && acc === a0, "R8", "result held", acc, a0);
      run_filter(10, 20, 1, 0, "R8");
      run_filter(40, 80, 2, 0, "R8");
   endtask

   task automatic t_wrap;
      put16(MEM_N - 2, 16'd1234);
      put16(0, 16'hFC18);
      put16(300, 16'd77);
      put16(302, 16'd55);
      run_filter(MEM_N - 2, 300, 2, 0, "R9");
   endtask

   initial begin
      for (int i = 0; i < MEM_N; i++) mem[i] = 8'((i * 37 + 11) % 251);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_multi();
      t_overflow();
      t_ignore_busy();
      t_zero();
      t_hold_and_b2b();
      t_wrap();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule